// File: doc/BRIEF.md
# Piecewise Nonlinear Error Gain

This block scales a signed error sample by a gain that depends on which band of the error axis the sample falls into. Four signed threshold registers cut the axis into five bands, and each band has its own unsigned fixed-point gain register. Near zero a control loop can run with a gentle gain. Once the error moves past a threshold a stronger (or weaker) gain takes over, so a large disturbance is corrected faster without making the loop nervous around its set point.

Thresholds need not be symmetric about zero, and they may all share one sign. For example, with four positive thresholds every negative error falls into the lowest band and only positive errors see a stepped profile. If software programs the thresholds out of order, the band selection still resolves to exactly one band. The rule is: the sample takes the first threshold, counting from index 0, that it lies strictly below; when it lies below none, it takes the top band. Each accepted sample produces one registered, saturated result one clock later.

Top module: `nl_err_gain`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `res_valid` is 0 and `res_err` is 0.
- R2: `res_valid` in any cycle equals `smp_valid` from the previous rising clock edge.
- R3: A sample strictly below threshold 0 is scaled by gain 0. This holds for any threshold profile, including one where all four thresholds are positive.
- R4: A sample with threshold k−1 ≤ sample < threshold k (k = 1, 2, 3) is scaled by gain k when the thresholds are non-decreasing.
- R5: A sample at or above threshold 3 is scaled by gain 4 when the thresholds are non-decreasing.
- R6: Gains are unsigned 8-bit values with 4 fractional bits (16 means 1.0). The result is floor(sample × gain / 16), so negative products round toward minus infinity. A zero sample gives a zero result.
- R7: A result above 2047 is clamped to 2047, and a result below −2048 is clamped to −2048 (12-bit signed output).
- R8: If the thresholds are out of order, the sample takes gain k for the lowest k in 0..3 with sample < threshold k, and gain 4 if there is no such k. Exactly one band is active for every sample.
- R9: A write with `cfg_we` high stores the value at `cfg_addr`. Addresses 0..3 are thresholds 0..3 and take `cfg_wdata[5:0]` as a 6-bit signed value. Addresses 4..8 are gains 0..4 and take all 8 bits of `cfg_wdata`. Writes to addresses 9..15 change nothing.
- R10: A sample accepted in the same cycle as a write uses the old register values, and the write applies to later samples. Without `smp_valid`, `res_err` holds its value.
- R11: After reset all thresholds are 0 and all gains are 16 (1.0), so samples pass through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | Sample strobe |
| smp_err | input | 12 | Signed error sample |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 8 | Register write data |
| res_valid | output | 1 | Result strobe, one cycle after `smp_valid` |
| res_err | output | 12 | Signed scaled and saturated error |

## Verification
The hardest situation to reach from the ports is band selection with out-of-order thresholds. Here the "between two thresholds" reading breaks down, and only the lowest-index rule decides the band. The stimulus writes deliberately scrambled thresholds with a distinct gain per band, then sweeps every error value across and beyond them, so a wrong band shows up as a wrong multiple. Saturation needs the largest gain together with full-scale samples, so a separate phase programs gain 255 into every band and drives both rails. A write issued in the same cycle as a sample checks the ordering rule in R10.

// File: rtl/nl_err_gain_pkg.sv
package nl_err_gain_pkg;
    localparam int N_THR   = 4;
    localparam int N_BANDS = N_THR + 1;
    localparam int THR_BASE  = 0;
    localparam int GAIN_BASE = N_THR;
    localparam int N_REGS    = N_THR + N_BANDS;
endpackage

// File: rtl/nl_err_gain_regs.sv
module nl_err_gain_regs
    import nl_err_gain_pkg::*;
#(
    parameter int THR_W   = 6,
    parameter int GAIN_W  = 8,
    parameter int GAIN_FR = 4,
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 8
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            cfg_we,
    input  logic [ADDR_W-1:0]               cfg_addr,
    input  logic [DATA_W-1:0]               cfg_wdata,
    output logic [N_THR-1:0][THR_W-1:0]     thr_o,
    output logic [N_BANDS-1:0][GAIN_W-1:0]  gain_o
);
    localparam logic [GAIN_W-1:0] GAIN_UNITY = GAIN_W'(1 << GAIN_FR);

    for (genvar i = 0; i < N_THR; i++) begin : g_thr
        logic [THR_W-1:0] thr_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                thr_q <= '0;
            end else if (cfg_we && cfg_addr == ADDR_W'(THR_BASE + i)) begin
                thr_q <= cfg_wdata[THR_W-1:0];
            end
        end
        assign thr_o[i] = thr_q;
    end

    for (genvar i = 0; i < N_BANDS; i++) begin : g_gain
        logic [GAIN_W-1:0] gain_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                gain_q <= GAIN_UNITY;
            end else if (cfg_we && cfg_addr == ADDR_W'(GAIN_BASE + i)) begin
                gain_q <= cfg_wdata[GAIN_W-1:0];
            end
        end
        assign gain_o[i] = gain_q;
    end

    // R9: a write outside the map leaves every register untouched
    p_ignore_r9: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_addr >= ADDR_W'(N_REGS)) |=> ($stable(thr_o) && $stable(gain_o)));
endmodule

// File: rtl/nl_err_gain_band.sv
module nl_err_gain_band
    import nl_err_gain_pkg::*;
#(
    parameter int ERR_W = 12,
    parameter int THR_W = 6
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic signed [ERR_W-1:0]     err_i,
    input  logic [N_THR-1:0][THR_W-1:0] thr_i,
    output logic [N_BANDS-1:0]          band_o
);
    logic [N_THR-1:0] below;

    for (genvar k = 0; k < N_THR; k++) begin : g_cmp
        logic signed [ERR_W-1:0] thr_ext;
        assign thr_ext  = ERR_W'($signed(thr_i[k]));
        assign below[k] = (err_i < thr_ext);
    end

    always_comb begin
        logic found;
        band_o = '0;
        found  = 1'b0;
        for (int k = 0; k < N_THR; k++) begin
            if (!found && below[k]) begin
                band_o[k] = 1'b1;
                found     = 1'b1;
            end
        end
        if (!found) begin
            band_o[N_THR] = 1'b1;
        end
    end

    // R8: exactly one band is active whatever the threshold order
    p_one_band_r8: assert property (@(posedge clk) disable iff (rst)
        $countones(band_o) == 1);
endmodule

// File: rtl/nl_err_gain_mul.sv
module nl_err_gain_mul #(
    parameter int ERR_W   = 12,
    parameter int GAIN_W  = 8,
    parameter int GAIN_FR = 4
) (
    input  logic signed [ERR_W-1:0] err_i,
    input  logic [GAIN_W-1:0]       gain_i,
    output logic signed [ERR_W-1:0] res_o
);
    localparam int PROD_W = ERR_W + GAIN_W + 1;
    localparam logic signed [PROD_W-1:0] HI = PROD_W'((1 << (ERR_W - 1)) - 1);
    localparam logic signed [PROD_W-1:0] LO = -HI - PROD_W'(1);

    logic signed [PROD_W-1:0] err_ext;
    logic signed [PROD_W-1:0] gain_ext;
    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] scaled;

    assign err_ext  = PROD_W'(err_i);
    assign gain_ext = $signed({{(ERR_W + 1){1'b0}}, gain_i});
    assign prod     = err_ext * gain_ext;
    assign scaled   = prod >>> GAIN_FR;

    always_comb begin
        if (scaled > HI) begin
            res_o = HI[ERR_W-1:0];
        end else if (scaled < LO) begin
            res_o = LO[ERR_W-1:0];
        end else begin
            res_o = scaled[ERR_W-1:0];
        end
    end
endmodule

// File: rtl/nl_err_gain.sv
module nl_err_gain
    import nl_err_gain_pkg::*;
#(
    parameter int ERR_W   = 12,
    parameter int THR_W   = 6,
    parameter int GAIN_W  = 8,
    parameter int GAIN_FR = 4,
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_valid,
    input  logic [ERR_W-1:0]  smp_err,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic              res_valid,
    output logic [ERR_W-1:0]  res_err
);
    logic [N_THR-1:0][THR_W-1:0]    thr;
    logic [N_BANDS-1:0][GAIN_W-1:0] gain;
    logic [N_BANDS-1:0]             band;
    logic [GAIN_W-1:0]              gain_sel;
    logic signed [ERR_W-1:0]        scaled;
    logic                           valid_q;
    logic [ERR_W-1:0]               res_q;

    nl_err_gain_regs #(
        .THR_W(THR_W), .GAIN_W(GAIN_W), .GAIN_FR(GAIN_FR),
        .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) regs_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .thr_o(thr), .gain_o(gain)
    );

    nl_err_gain_band #(.ERR_W(ERR_W), .THR_W(THR_W)) band_i (
        .clk(clk), .rst(rst), .err_i($signed(smp_err)), .thr_i(thr), .band_o(band)
    );

    always_comb begin
        gain_sel = '0;
        for (int k = 0; k < N_BANDS; k++) begin
            gain_sel |= gain[k] & {GAIN_W{band[k]}};
        end
    end

    nl_err_gain_mul #(.ERR_W(ERR_W), .GAIN_W(GAIN_W), .GAIN_FR(GAIN_FR)) mul_i (
        .err_i($signed(smp_err)), .gain_i(gain_sel), .res_o(scaled)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            res_q   <= '0;
        end else begin
            valid_q <= smp_valid;
            if (smp_valid) begin
                res_q <= scaled;
            end
        end
    end

    assign res_valid = valid_q;
    assign res_err   = res_q;

    // R2: result strobe trails the sample strobe by one clock
    p_valid_follow_r2: assert property (@(posedge clk) disable iff (rst)
        res_valid == $past(smp_valid));
    // R10: result holds when no sample arrives
    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> $stable(res_err));
    // R6: a zero sample yields a zero result
    p_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && smp_err == '0) |=> (res_err == '0));
    // R7: saturation never flips the sign of a non-negative sample
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && !smp_err[ERR_W-1]) |=> !res_err[ERR_W-1]);
endmodule

// File: tb/nl_err_gain_tb.sv
module nl_err_gain_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_valid = 1'b0;
    logic [11:0] smp_err = '0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        res_valid;
    logic [11:0] res_err;

    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    int m_thr[4];
    int m_gain[5];
    int m_valid;
    int m_data;

    always #2 clk = ~clk;

    nl_err_gain dut_i (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_err(smp_err),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .res_valid(res_valid), .res_err(res_err)
    );

    function automatic int ref_gain(int e);
        int g;
        longint p;
        longint q;
        g = m_gain[4];
        for (int k = 3; k >= 0; k--) begin
            if (e < m_thr[k]) g = m_gain[k];
        end
        p = longint'(e) * longint'(g);
        q = p >>> 4;
        if (q > 2047) q = 2047;
        if (q < -2048) q = -2048;
        return int'(q);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_valid <= 0;
            m_data  <= 0;
            for (int k = 0; k < 4; k++) m_thr[k] <= 0;
            for (int k = 0; k < 5; k++) m_gain[k] <= 16;
        end else begin
            m_valid <= int'(smp_valid);
            if (smp_valid) m_data <= ref_gain(int'($signed(smp_err)));
            if (cfg_we) begin
                if (cfg_addr < 4) m_thr[cfg_addr] <= int'($signed(cfg_wdata[5:0]));
                else if (cfg_addr < 9) m_gain[cfg_addr - 4] <= int'(cfg_wdata);
            end
        end
    end

    always @(negedge clk) begin
        cycles++;
        if (!rst && !done) begin
            checks++;
            if (int'(res_valid) != m_valid) begin
                errors++;
                $display("FAIL %s valid: actual %0d expected %0d", cur_req, res_valid, m_valid);
            end
            checks++;
            if (int'($signed(res_err)) != m_data) begin
                errors++;
                $display("FAIL %s data: actual %0d expected %0d", cur_req,
                         $signed(res_err), m_data);
            end
        end
    end

    always @(negedge clk) begin
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic wr(int a, int d);
        @(negedge clk);
        smp_valid = 1'b0;
        cfg_we = 1'b1;
        cfg_addr = 4'(a);
        cfg_wdata = 8'(d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic smp(int e);
        @(negedge clk);
        cfg_we = 1'b0;
        smp_valid = 1'b1;
        smp_err = 12'(e);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            smp_valid = 1'b0;
            cfg_we = 1'b0;
        end
    endtask

    task automatic sweep(int lo, int hi);
        for (int e = lo; e <= hi; e++) smp(e);
        idle(2);
    endtask

    task automatic set_thr(int t0, int t1, int t2, int t3);
        wr(0, t0 & 63); wr(1, t1 & 63); wr(2, t2 & 63); wr(3, t3 & 63);
    endtask

    task automatic set_gain(int g0, int g1, int g2, int g3, int g4);
        wr(4, g0); wr(5, g1); wr(6, g2); wr(7, g3); wr(8, g4);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs clear under reset
        checks++;
        if (res_valid !== 1'b0 || res_err !== 12'd0) begin
            errors++;
            $display("FAIL R1 reset: actual %0d/%0d expected 0/0", res_valid, res_err);
        end
        rst = 1'b0;
        cur_req = "R1";
        idle(1);
        cur_req = "R11";
        smp(100); smp(-37); smp(2047); smp(-2048);
        idle(3);
        cur_req = "R2";
        smp(5); idle(1); smp(6); smp(7); idle(2);
        // symmetric profile
        set_thr(-20, -6, 6, 20);
        set_gain(64, 32, 16, 32, 64);
        cur_req = "R3"; sweep(-40, -21);
        cur_req = "R4"; sweep(-20, 19);
        cur_req = "R5"; sweep(20, 40);
        cur_req = "R6";
        wr(6, 24);
        sweep(-6, 5);
        smp(0); idle(2);
        cur_req = "R7";
        set_gain(255, 255, 255, 255, 255);
        smp(2047); smp(-2048); smp(1000); smp(-1000); smp(100); smp(-129); smp(128);
        idle(2);
        cur_req = "R3";
        set_thr(2, 5, 9, 20);
        set_gain(48, 16, 32, 8, 80);
        sweep(-10, 25);
        cur_req = "R8";
        set_thr(10, -5, 3, -20);
        set_gain(16, 32, 48, 64, 80);
        sweep(-30, 30);
        cur_req = "R9";
        for (int a = 9; a < 16; a++) wr(a, 255);
        sweep(-30, 30);
        cur_req = "R10";
        @(negedge clk);
        smp_valid = 1'b1; smp_err = 12'd15;
        cfg_we = 1'b1; cfg_addr = 4'd8; cfg_wdata = 8'd160;
        smp(15); smp(15);
        idle(4);
        cur_req = "R7";
        for (int i = 0; i < 200; i++) smp(((i * 1103) % 4096) - 2048);
        idle(3);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule